// File: doc/BRIEF.md
# Bit-Serial Arithmetic Logic Slice

This block is the one-bit processing slice of a minimal bit-serial controller. It holds a result bit register (RR) and a carry flag (C). A Boolean logic unit sits in front of them, and a small carry network turns that logic unit into a serial full adder and subtractor. Each instruction handles one bit. A multi-bit sum or difference is built by running the same add or subtract operation over the operand bits from the least significant bit upward, while C carries the running carry or borrow from one bit to the next.

An external decoder supplies a four-bit operation code and separate write enables for RR and C. The memory data bit enters through a data-in enable gate. Clearing that enable turns the operand into a constant 0, so carry-only increments and similar steps are possible. The bit driven back to memory is RR or its complement, chosen by an invert control.

Top module: `bit_serial_alu`

## Requirements
- R1: While the active-low reset is asserted, RR and C are 0. With the invert control low, the store bit is then 0.
- R2: On a clock edge, RR changes only when its write enable is 1, and C changes only when its write enable is 1. A register whose enable is 0 keeps its value whatever the operation code.
- R3: Every operation sees an operand bit M equal to the memory bit AND the data-in enable. With the enable at 0, every operation behaves as if the memory bit were 0.
- R4: Logic operations write RR as follows: code 0 loads M, code 1 loads NOT M, code 2 loads RR AND M, code 3 loads RR OR M, code 4 loads RR XNOR M. The C value they produce is 0.
- R5: Code 5 (add with carry) writes RR = RR XOR M XOR C and writes C = the majority of RR, M and C.
- R6: Code 6 (subtract with borrow, computed as RR + NOT M + C) writes RR = RR XOR NOT M XOR C and writes C = the majority of RR, NOT M and C. C = 1 means no borrow.
- R7: First-bit variants ignore C and use a fixed carry-in: code 7 adds with carry-in 0, code 8 adds with carry-in 1, code 9 subtracts with carry-in 1, and code 10 subtracts with carry-in 0.
- R8: Code 11 writes RR = C and produces a C value of 0.
- R9: Code 12 writes C = RR, ignoring M, and produces an RR value of 0.
- R10: The store bit equals RR when the invert control is 0 and NOT RR when it is 1.
- R11: Codes 13 to 15 produce 0 for both RR and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| mem_i | input | 1 | Memory data bit |
| din_en_i | input | 1 | Data-in enable, ANDed with mem_i |
| rr_we_i | input | 1 | RR write enable |
| c_we_i | input | 1 | C write enable |
| inv_store_i | input | 1 | Complement the store bit |
| rr_o | output | 1 | Result register |
| c_o | output | 1 | Carry flag |
| store_o | output | 1 | Bit written back to memory |

## Verification
Every operation code is applied with every combination of RR, C, memory bit and data-in enable, and with both write enables on and both off. This sweep separates the gated carry path from the forced carry path, and the add generate term from the subtract generate term. It also shows that disabled registers hold their value.

Full 16-bit additions and subtractions are then run bit by bit on several operand pairs: all ones plus one, a zero difference, a borrow out of zero, sign-bit overflow, and mixed values. These runs show that the carry ripples correctly across many bits and that the final C flag is right. A carry-only increment with the data-in enable held low shows that the operand is masked and that the forced carry-in on the first bit takes effect.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LD   = 4'd0,
    OP_LDC  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XNOR = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_ADD0 = 4'd7,
    OP_ADD1 = 4'd8,
    OP_SUB1 = 4'd9,
    OP_SUB0 = 4'd10,
    OP_RRC  = 4'd11,
    OP_CRR  = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    LU_ZERO, LU_PASS, LU_INV, LU_AND, LU_OR, LU_XOR, LU_XNOR
  } lu_fn_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_FLAG, CIN_ONE
  } cin_sel_e;

  typedef struct packed {
    lu_fn_e   lu_fn;
    cin_sel_e cin_sel;
    logic     gen_add;  // rr & m
    logic     gen_sub;  // rr & ~m
  } ctrl_t;
endpackage

// File: rtl/bsa_decode.sv
module bsa_decode
  import bsa_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{lu_fn: LU_ZERO, cin_sel: CIN_ZERO, gen_add: 1'b0, gen_sub: 1'b0};
    case (op_i)
      OP_LD:   ctrl_o.lu_fn = LU_PASS;
      OP_LDC:  ctrl_o.lu_fn = LU_INV;
      OP_AND:  ctrl_o.lu_fn = LU_AND;
      OP_OR:   ctrl_o.lu_fn = LU_OR;
      OP_XNOR: ctrl_o.lu_fn = LU_XNOR;
      OP_ADC:  ctrl_o = '{lu_fn: LU_XOR,  cin_sel: CIN_FLAG, gen_add: 1'b1, gen_sub: 1'b0};
      OP_SBC:  ctrl_o = '{lu_fn: LU_XNOR, cin_sel: CIN_FLAG, gen_add: 1'b0, gen_sub: 1'b1};
      OP_ADD0: ctrl_o = '{lu_fn: LU_XOR,  cin_sel: CIN_ZERO, gen_add: 1'b1, gen_sub: 1'b0};
      OP_ADD1: ctrl_o = '{lu_fn: LU_XOR,  cin_sel: CIN_ONE,  gen_add: 1'b1, gen_sub: 1'b0};
      OP_SUB1: ctrl_o = '{lu_fn: LU_XNOR, cin_sel: CIN_ONE,  gen_add: 1'b0, gen_sub: 1'b1};
      OP_SUB0: ctrl_o = '{lu_fn: LU_XNOR, cin_sel: CIN_ZERO, gen_add: 1'b0, gen_sub: 1'b1};
      // C -> RR: zero LU, let flag through the sum XOR
      OP_RRC:  ctrl_o.cin_sel = CIN_FLAG;
      // RR -> C: both generate terms cover both values of m
      OP_CRR:  begin ctrl_o.gen_add = 1'b1; ctrl_o.gen_sub = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsa_logic_unit.sv
module bsa_logic_unit
  import bsa_pkg::*;
(
  input  lu_fn_e fn_i,
  input  logic   rr_i,
  input  logic   m_i,
  output logic   lu_o
);
  always_comb begin
    case (fn_i)
      LU_PASS: lu_o = m_i;
      LU_INV:  lu_o = ~m_i;
      LU_AND:  lu_o = rr_i & m_i;
      LU_OR:   lu_o = rr_i | m_i;
      LU_XOR:  lu_o = rr_i ^ m_i;
      LU_XNOR: lu_o = ~(rr_i ^ m_i);
      default: lu_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsa_carry.sv
module bsa_carry
  import bsa_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  logic  c_i,
  input  logic  rr_i,
  input  logic  m_i,
  input  logic  prop_i,
  output logic  cin_o,
  output logic  c_next_o
);
  logic gen;

  always_comb begin
    cin_o    = ((ctrl_i.cin_sel == CIN_FLAG) & c_i) | (ctrl_i.cin_sel == CIN_ONE);
    gen      = (ctrl_i.gen_add & rr_i & m_i) | (ctrl_i.gen_sub & rr_i & ~m_i);
    c_next_o = gen | (prop_i & cin_o);
  end
endmodule

// File: rtl/bit_serial_alu.sv
module bit_serial_alu
  import bsa_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            mem_i,
  input  logic            din_en_i,
  input  logic            rr_we_i,
  input  logic            c_we_i,
  input  logic            inv_store_i,
  output logic            rr_o,
  output logic            c_o,
  output logic            store_o
);
  ctrl_t ctrl;
  logic  m_eff, lu, cin, c_next, rr_q, c_q;

  assign m_eff = mem_i & din_en_i;

  bsa_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  bsa_logic_unit u_lu (.fn_i(ctrl.lu_fn), .rr_i(rr_q), .m_i(m_eff), .lu_o(lu));

  bsa_carry u_cy (
    .ctrl_i(ctrl), .c_i(c_q), .rr_i(rr_q), .m_i(m_eff),
    .prop_i(lu), .cin_o(cin), .c_next_o(c_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      if (rr_we_i) rr_q <= lu ^ cin;
      if (c_we_i)  c_q  <= c_next;
    end
  end

  assign rr_o    = rr_q;
  assign c_o     = c_q;
  assign store_o = rr_q ^ inv_store_i;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker
  import bsa_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic            mem_i,
  input logic            din_en_i,
  input logic            rr_we_i,
  input logic            c_we_i,
  input logic            rr_o,
  input logic            c_o
);
  logic m;
  assign m = mem_i & din_en_i;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!rr_o && !c_o); // R1
    end
  end

  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rr_we_i |=> $stable(rr_o)); // R2
  AST_C_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_we_i |=> $stable(c_o)); // R2
  AST_DIN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_we_i && op_i == OP_LD && !din_en_i) |=> !rr_o); // R3
  AST_ADC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_we_i && op_i == OP_ADC) |=> rr_o == ($past(rr_o) ^ $past(m) ^ $past(c_o))); // R5
  AST_ADC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_we_i && op_i == OP_ADC) |=>
      c_o == (($past(rr_o) & $past(m)) | ($past(rr_o) & $past(c_o)) | ($past(m) & $past(c_o)))); // R5
  AST_SBC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_we_i && op_i == OP_SBC) |=> rr_o == ($past(rr_o) ^ !$past(m) ^ $past(c_o))); // R6
  AST_RRC_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_we_i && op_i == OP_RRC) |=> rr_o == $past(c_o)); // R8
  AST_CRR_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_we_i && op_i == OP_CRR) |=> c_o == $past(rr_o)); // R9
endmodule

bind bit_serial_alu bsa_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .mem_i(mem_i),
  .din_en_i(din_en_i), .rr_we_i(rr_we_i), .c_we_i(c_we_i),
  .rr_o(rr_o), .c_o(c_o)
);

// File: tb/tb_bit_serial_alu.sv
module tb_bit_serial_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [3:0] op_i = '0;
  logic       mem_i = 1'b0, din_en_i = 1'b1, rr_we_i = 1'b0, c_we_i = 1'b0, inv_store_i = 1'b0;
  logic       rr_o, c_o, store_o;

  int checks = 0, failures = 0;
  bit m_rr = 0, m_c = 0;  // reference state

  always #4 clk_i = ~clk_i;

  bit_serial_alu dut (.*);

  function automatic string tag_of(input int op);
    if (op <= 4)  return "R4";
    if (op == 5)  return "R5";
    if (op == 6)  return "R6";
    if (op <= 10) return "R7";
    if (op == 11) return "R8";
    if (op == 12) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input bit m, input bit din, input bit rwe,
                      input bit cwe, input bit inv, input string tag);
    bit eff, nr, nc, b, ci;
    int s;
    op_i = 4'(op); mem_i = m; din_en_i = din; rr_we_i = rwe; c_we_i = cwe; inv_store_i = inv;
    eff = m & din;
    nr = 0; nc = 0;
    case (op)
      0: nr = eff;
      1: nr = !eff;
      2: nr = m_rr & eff;
      3: nr = m_rr | eff;
      4: nr = (m_rr == eff);
      5, 6, 7, 8, 9, 10: begin
        b  = (op == 6 || op == 9 || op == 10) ? !eff : eff;
        ci = (op == 5 || op == 6) ? m_c : (op == 8 || op == 9);
        s  = int'(m_rr) + int'(b) + int'(ci);
        nr = s[0]; nc = s[1];
      end
      11: nr = m_c;
      12: nc = m_rr;
      default: ;
    endcase
    if (rwe) m_rr = nr;
    if (cwe) m_c = nc;
    @(posedge clk_i); #1;
    check(rwe ? tag : "R2", "rr", rr_o, m_rr);
    check(cwe ? tag : "R2", "c", c_o, m_c);
    check("R10", "store", store_o, m_rr ^ inv);
  endtask

  // put reference and design into rr=x, c=y
  task automatic preset(input bit x, input bit y);
    step(0, y, 1, 1, 0, 0, "R4");
    step(12, 0, 1, 0, 1, 1, "R9");
    step(0, x, 1, 1, 0, 0, "R4");
  endtask

  task automatic add16(input int a, input int b, input bit sub);
    int res = 0;
    int exp;
    for (int i = 0; i < 16; i++) begin
      step(0, a[i], 1, 1, 0, 0, "R4");
      if (sub) step(i == 0 ? 9 : 6, b[i], 1, 1, 1, 0, i == 0 ? "R7" : "R6");
      else     step(i == 0 ? 7 : 5, b[i], 1, 1, 1, 0, i == 0 ? "R7" : "R5");
      res[i] = rr_o;
    end
    exp = sub ? (a + ((~b) & 16'hFFFF) + 1) : (a + b);
    check(sub ? "R6" : "R5", "word", res, exp & 16'hFFFF);
    check(sub ? "R6" : "R5", "carry_out", c_o, (exp >> 16) & 1);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #20;
    check("R1", "rr_reset", rr_o, 0);
    check("R1", "c_reset", c_o, 0);
    check("R1", "store_reset", store_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // exhaustive single-bit sweep
    for (int op = 0; op < 16; op++)
      for (int v = 0; v < 32; v++) begin
        preset(v[0], v[1]);
        step(op, v[2], v[3], v[4], v[4], v[0] ^ v[3], tag_of(op));
      end

    // R3: operand masked when data-in disabled
    preset(1, 1);
    step(3, 1, 0, 1, 1, 0, "R3");
    check("R3", "or_masked_rr", rr_o, 1);
    step(0, 1, 0, 1, 0, 0, "R3");
    check("R3", "ld_masked", rr_o, 0);

    // multi-bit arithmetic
    add16(16'hFFFF, 16'h0001, 0);
    add16(16'h1234, 16'hABCD, 0);
    add16(16'h8000, 16'h8000, 0);
    add16(16'h0000, 16'h0000, 0);
    add16(16'h1234, 16'h1234, 1);
    add16(16'h0000, 16'h0001, 1);
    add16(16'hABCD, 16'h1234, 1);

    // increment via forced carry, operand masked (R3, R7)
    begin
      int a = 16'h00FF, res = 0;
      for (int i = 0; i < 16; i++) begin
        step(0, a[i], 1, 1, 0, 0, "R4");
        step(i == 0 ? 8 : 5, 1, 0, 1, 1, 0, "R7");
        res[i] = rr_o;
      end
      check("R7", "increment", res, 16'h0100);
    end

    // mid-run reset
    preset(1, 1);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    m_rr = 0; m_c = 0;
    check("R1", "rr_midreset", rr_o, 0);
    check("R1", "c_midreset", c_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule